// File: doc/BRIEF.md
# Background Tile Fetch Sequencer

This block drives the background half of a tile-based video generator's memory traffic for one scanline. From the horizontal dot counter, the line number and the current video memory address `v`, it decides which dots issue a read, forms the read address, and captures the returned byte into a set of next-tile registers: the tile index, a palette offset and two pattern-plane bytes. At the start of every eight-dot tile slot the pattern bytes fetched during the previous slot are merged into two 16-bit background shift registers. Downstream pixel logic reads these registers.

Between the visible tile fetches and the prefetch of the next line's first two tiles, the block issues the exact throwaway nametable and attribute reads that the real bus shows, and it issues two more nametable reads at the end of the line. External cartridge logic that watches the address bus to count lines therefore sees the real address pattern. The block also flags the single dot that is dropped on the pre-render line of odd frames in NTSC timing. The block does no sprite work, no pixel selection and no scroll update. `v` comes from outside.

Top module: `bgf_fetch_seq`

## Requirements
- R1: After reset, tileIdx, palOffset, patLo, patHi, shiftLo and shiftHi are zero, and rdStrobe is low.
- R2: On a fetch line (scanline 0..239 or 261) with renderEn high, dots 1..256 and 321..336 fetch by dot modulo 8. Value 1 reads the nametable at 0x2000 | (v & 0x0FFF). Value 2 reads the attribute byte. Value 3 reads the low pattern plane. Value 5 reads the high pattern plane. Values 0, 4, 6 and 7 issue no read.
- R3: The attribute read address is 0x23C0 | (v & 0x0C00) | ((v >> 4) & 0x38) | ((v >> 2) & 0x07).
- R4: The low-plane address is (bgPatSel ? 0x1000 : 0) | (tileIdx << 4) | (v >> 12), where tileIdx is the registered tile index. The high-plane address is that value plus 8.
- R5: At the clock edge that ends a tile-region read dot, rdData is captured. A nametable read goes to tileIdx, a low-plane read to patLo, and a high-plane read to patHi. An attribute read sets palOffset to ((rdData >> s) & 3) << 2, with s = ((v >> 4) & 4) | (v & 2).
- R6: In dots 257..320 of a fetch line, a dummy nametable read is issued at every dot with dot modulo 8 equal to 1, and a dummy attribute read at every dot with modulo 8 equal to 3. No other dot in that range reads, and no next-tile register changes.
- R7: Dots 337 and 339 of a fetch line each issue a nametable read, with the R2 address, that loads no register. Dots 0, 338 and 340 issue no read.
- R8: On every tile-region dot (1..256, 321..336) of an active fetch line, shiftLo and shiftHi shift left by one bit. On dots with modulo 8 equal to 1, the previously captured patLo and patHi are also ORed into bits 7:0 of the shifted value.
- R9: skipDot is high only when renderEn, ntscMode and oddFrame are all high, scanline is 261 and dot is 339.
- R10: With renderEn low, or on scanlines 240..260, rdStrobe stays low, busAddr is 0 and no register changes. busAddr is also 0 on any dot without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rstN | input | 1 | Asynchronous active-low reset |
| dot | input | 9 | Current dot within the line (0..340) |
| scanline | input | 9 | Current line (0..261, 261 = pre-render) |
| renderEn | input | 1 | Background or sprite rendering enabled |
| oddFrame | input | 1 | Frame parity, high on odd frames |
| ntscMode | input | 1 | High for the timing mode that drops a dot |
| vramAddr | input | 15 | Current video memory address v |
| bgPatSel | input | 1 | Background pattern table select (0x0000 / 0x1000) |
| rdData | input | 8 | Byte returned for busAddr in the same cycle |
| busAddr | output | 14 | Read address, 0 when no read |
| rdStrobe | output | 1 | Read issued this dot |
| skipDot | output | 1 | This dot is the one to be skipped |
| tileIdx | output | 8 | Next-tile index |
| palOffset | output | 4 | Next-tile palette offset (bits 3:2 used) |
| patLo | output | 8 | Next-tile low pattern byte |
| patHi | output | 8 | Next-tile high pattern byte |
| shiftLo | output | 16 | Low-plane background shift register |
| shiftHi | output | 16 | High-plane background shift register |

## Verification
rdStrobe, busAddr and skipDot come from combinational decode of the current dot inputs. They are due in the same cycle that the dot is presented. The bench drives each dot on the falling edge and samples these outputs 2 ns later. The next-tile registers and shifters take one edge, so the bench reads them 2 ns after the rising edge that ends the dot. It compares them with a model that it updates from R2 to R8, and it supplies rdData from an address-hashed memory function.

// File: rtl/bgf_pkg.sv
package bgf_pkg;
  typedef enum logic [1:0] {
    SEL_NT  = 2'd0,
    SEL_AT  = 2'd1,
    SEL_PLO = 2'd2,
    SEL_PHI = 2'd3
  } fetchSel_e;

  typedef struct packed {
    logic      rdEn;
    fetchSel_e sel;
    logic      ldNt;
    logic      ldAt;
    logic      ldLo;
    logic      ldHi;
    logic      shiftEn;
    logic      shiftLoad;
  } fetchCtl_t;
endpackage

// File: rtl/bgf_ctrl.sv
module bgf_ctrl
  import bgf_pkg::*;
#(
  parameter int DOT_W         = 9,
  parameter int LINE_W        = 9,
  parameter int VISIBLE_LINES = 240,
  parameter int PRE_LINE      = 261,
  parameter int TILE_END      = 256,
  parameter int SPR_END       = 320,
  parameter int PREF_END      = 336,
  parameter int EXTRA_NT_A    = 337,
  parameter int EXTRA_NT_B    = 339,
  parameter int SKIP_AT       = 339,
  parameter int SLOT_W        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] scanline,
  input  logic              renderEn,
  input  logic              oddFrame,
  input  logic              ntscMode,
  output fetchCtl_t         ctl,
  output logic              skipDot
);
  localparam logic [DOT_W-1:0]  DotOne    = DOT_W'(1);
  localparam logic [DOT_W-1:0]  DotTile   = DOT_W'(TILE_END);
  localparam logic [DOT_W-1:0]  DotSprLo  = DOT_W'(TILE_END + 1);
  localparam logic [DOT_W-1:0]  DotSprHi  = DOT_W'(SPR_END);
  localparam logic [DOT_W-1:0]  DotPrefLo = DOT_W'(SPR_END + 1);
  localparam logic [DOT_W-1:0]  DotPrefHi = DOT_W'(PREF_END);
  localparam logic [DOT_W-1:0]  DotExA    = DOT_W'(EXTRA_NT_A);
  localparam logic [DOT_W-1:0]  DotExB    = DOT_W'(EXTRA_NT_B);
  localparam logic [DOT_W-1:0]  DotSkip   = DOT_W'(SKIP_AT);
  localparam logic [LINE_W-1:0] LineVis   = LINE_W'(VISIBLE_LINES);
  localparam logic [LINE_W-1:0] LinePre   = LINE_W'(PRE_LINE);
  localparam logic [SLOT_W-1:0] StepNt    = SLOT_W'(1);
  localparam logic [SLOT_W-1:0] StepAt    = SLOT_W'(2);
  localparam logic [SLOT_W-1:0] StepLo    = SLOT_W'(3);
  localparam logic [SLOT_W-1:0] StepHi    = SLOT_W'(5);

  logic              fetchLine;
  logic              active;
  logic              inTile;
  logic              inSpr;
  logic              extraNt;
  logic [SLOT_W-1:0] step;

  assign fetchLine = (scanline < LineVis) || (scanline == LinePre);
  assign active    = renderEn && fetchLine;
  assign inTile    = ((dot >= DotOne) && (dot <= DotTile)) ||
                     ((dot >= DotPrefLo) && (dot <= DotPrefHi));
  assign inSpr     = (dot >= DotSprLo) && (dot <= DotSprHi);
  assign extraNt   = (dot == DotExA) || (dot == DotExB);
  assign step      = dot[SLOT_W-1:0];

  always_comb begin
    ctl     = '0;
    ctl.sel = SEL_NT;
    if (active) begin
      if (inTile) begin
        ctl.shiftEn   = 1'b1;
        ctl.shiftLoad = (step == StepNt);
        case (step)
          StepNt: begin ctl.rdEn = 1'b1; ctl.sel = SEL_NT;  ctl.ldNt = 1'b1; end
          StepAt: begin ctl.rdEn = 1'b1; ctl.sel = SEL_AT;  ctl.ldAt = 1'b1; end
          StepLo: begin ctl.rdEn = 1'b1; ctl.sel = SEL_PLO; ctl.ldLo = 1'b1; end
          StepHi: begin ctl.rdEn = 1'b1; ctl.sel = SEL_PHI; ctl.ldHi = 1'b1; end
          default: ;
        endcase
      end else if (inSpr) begin
        if (step == StepNt) begin
          ctl.rdEn = 1'b1;
          ctl.sel  = SEL_NT;
        end else if (step == StepLo) begin
          ctl.rdEn = 1'b1;
          ctl.sel  = SEL_AT;
        end
      end else if (extraNt) begin
        ctl.rdEn = 1'b1;
        ctl.sel  = SEL_NT;
      end
    end
  end

  assign skipDot = renderEn && ntscMode && oddFrame &&
                   (scanline == LinePre) && (dot == DotSkip);

  a_r10_no_read_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !renderEn |-> !ctl.rdEn);
  a_r9_skip_position: assert property (@(posedge clk) disable iff (!rstN)
    skipDot |-> (dot == DotSkip && scanline == LinePre && oddFrame));
  a_r5_single_load: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.ldNt, ctl.ldAt, ctl.ldLo, ctl.ldHi}));
  a_r2_load_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.ldNt || ctl.ldAt || ctl.ldLo || ctl.ldHi) |-> (ctl.rdEn && ctl.shiftEn));
endmodule

// File: rtl/bgf_datapath.sv
module bgf_datapath
  import bgf_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int V_W    = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  fetchCtl_t           ctl,
  input  logic [V_W-1:0]      vramAddr,
  input  logic                bgPatSel,
  input  logic [DATA_W-1:0]   rdData,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                rdStrobe,
  output logic [DATA_W-1:0]   tileIdx,
  output logic [3:0]          palOffset,
  output logic [DATA_W-1:0]   patLo,
  output logic [DATA_W-1:0]   patHi,
  output logic [2*DATA_W-1:0] shiftLo,
  output logic [2*DATA_W-1:0] shiftHi
);
  localparam int SHIFT_W = 2 * DATA_W;

  logic [ADDR_W-1:0] ntAddr;
  logic [ADDR_W-1:0] atAddr;
  logic [ADDR_W-1:0] patAddrLo;
  logic [ADDR_W-1:0] patAddrHi;
  logic [1:0]        quadSel;
  logic [1:0]        palPick;
  logic [1:0]        palReg;

  // Nametable: fixed 0x2000 window plus the low 12 bits of v.
  assign ntAddr    = {2'b10, vramAddr[11:0]};
  // Attribute: table at end of the selected nametable, coarse X/Y divided by four.
  assign atAddr    = {2'b10, vramAddr[11:10], 4'b1111, vramAddr[9:7], vramAddr[4:2]};
  // Pattern: table select, tile index, plane bit, fine Y.
  assign patAddrLo = {1'b0, bgPatSel, tileIdx, 1'b0, vramAddr[14:12]};
  assign patAddrHi = {1'b0, bgPatSel, tileIdx, 1'b1, vramAddr[14:12]};

  always_comb begin
    busAddr = '0;
    if (ctl.rdEn) begin
      case (ctl.sel)
        SEL_NT:  busAddr = ntAddr;
        SEL_AT:  busAddr = atAddr;
        SEL_PLO: busAddr = patAddrLo;
        SEL_PHI: busAddr = patAddrHi;
        default: busAddr = '0;
      endcase
    end
  end
  assign rdStrobe = ctl.rdEn;

  // Quadrant of the 32x32 area: bit 1 of coarse Y and bit 1 of coarse X.
  assign quadSel = {vramAddr[6], vramAddr[1]};
  always_comb begin
    case (quadSel)
      2'd0:    palPick = rdData[1:0];
      2'd1:    palPick = rdData[3:2];
      2'd2:    palPick = rdData[5:4];
      default: palPick = rdData[7:6];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tileIdx <= '0;
      palReg  <= '0;
      patLo   <= '0;
      patHi   <= '0;
      shiftLo <= '0;
      shiftHi <= '0;
    end else begin
      if (ctl.ldNt) tileIdx <= rdData;
      if (ctl.ldAt) palReg  <= palPick;
      if (ctl.ldLo) patLo   <= rdData;
      if (ctl.ldHi) patHi   <= rdData;
      if (ctl.shiftEn) begin
        shiftLo <= {shiftLo[SHIFT_W-2:0], 1'b0} |
                   (ctl.shiftLoad ? {{DATA_W{1'b0}}, patLo} : '0);
        shiftHi <= {shiftHi[SHIFT_W-2:0], 1'b0} |
                   (ctl.shiftLoad ? {{DATA_W{1'b0}}, patHi} : '0);
      end
    end
  end

  assign palOffset = {palReg, 2'b00};

  a_r4_plane_bit: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && (ctl.sel == SEL_PLO || ctl.sel == SEL_PHI)) |->
      (busAddr[3] == (ctl.sel == SEL_PHI)) && !busAddr[ADDR_W-1]);
  a_r3_attr_window: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && ctl.sel == SEL_AT) |-> (busAddr[9:6] == 4'hF && busAddr[13]));
  a_r10_idle_addr: assert property (@(posedge clk) disable iff (!rstN)
    !rdStrobe |-> (busAddr == '0));
  a_r8_shift_step: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.shiftEn && !ctl.shiftLoad) |=> (shiftLo[0] == 1'b0 && shiftHi[0] == 1'b0));
endmodule

// File: rtl/bgf_fetch_seq.sv
module bgf_fetch_seq
  import bgf_pkg::*;
#(
  parameter int DOT_W  = 9,
  parameter int LINE_W = 9,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  parameter int V_W    = 15
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [DOT_W-1:0]    dot,
  input  logic [LINE_W-1:0]   scanline,
  input  logic                renderEn,
  input  logic                oddFrame,
  input  logic                ntscMode,
  input  logic [V_W-1:0]      vramAddr,
  input  logic                bgPatSel,
  input  logic [DATA_W-1:0]   rdData,
  output logic [ADDR_W-1:0]   busAddr,
  output logic                rdStrobe,
  output logic                skipDot,
  output logic [DATA_W-1:0]   tileIdx,
  output logic [3:0]          palOffset,
  output logic [DATA_W-1:0]   patLo,
  output logic [DATA_W-1:0]   patHi,
  output logic [2*DATA_W-1:0] shiftLo,
  output logic [2*DATA_W-1:0] shiftHi
);
  fetchCtl_t ctl;

  bgf_ctrl #(.DOT_W(DOT_W), .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dot(dot), .scanline(scanline),
    .renderEn(renderEn), .oddFrame(oddFrame), .ntscMode(ntscMode),
    .ctl(ctl), .skipDot(skipDot)
  );

  bgf_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .V_W(V_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .vramAddr(vramAddr),
    .bgPatSel(bgPatSel), .rdData(rdData), .busAddr(busAddr),
    .rdStrobe(rdStrobe), .tileIdx(tileIdx), .palOffset(palOffset),
    .patLo(patLo), .patHi(patHi), .shiftLo(shiftLo), .shiftHi(shiftHi)
  );

  a_r10_frozen_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !renderEn |=> ($stable(tileIdx) && $stable(patLo) && $stable(patHi) &&
                   $stable(palOffset) && $stable(shiftLo) && $stable(shiftHi)));
  a_r7_tail_reads_no_load: assert property (@(posedge clk) disable iff (!rstN)
    (dot > DOT_W'(336)) |=> ($stable(tileIdx) && $stable(shiftLo)));
  a_r6_dummy_reads_in_nt_space: assert property (@(posedge clk) disable iff (!rstN)
    (rdStrobe && dot > DOT_W'(256) && dot < DOT_W'(321)) |-> busAddr[ADDR_W-1]);
endmodule

// File: tb/test_bgf_fetch_seq.sv
module test_bgf_fetch_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [8:0]  dot = '0;
  logic [8:0]  scanline = '0;
  logic        renderEn = 1'b0;
  logic        oddFrame = 1'b0;
  logic        ntscMode = 1'b0;
  logic [14:0] vramAddr = '0;
  logic        bgPatSel = 1'b0;
  logic [7:0]  rdData;
  logic [13:0] busAddr;
  logic        rdStrobe, skipDot;
  logic [7:0]  tileIdx, patLo, patHi;
  logic [3:0]  palOffset;
  logic [15:0] shiftLo, shiftHi;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0]  eTile = '0, eLo = '0, eHi = '0;
  logic [3:0]  ePal = '0;
  logic [15:0] eShL = '0, eShH = '0;

  always #10 clk = ~clk;

  function automatic logic [7:0] memFn(logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b01} ^ 8'h3C;
  endfunction
  assign rdData = memFn(busAddr);

  bgf_fetch_seq i_bgf_fetch_seq (
    .clk(clk), .rstN(rstN), .dot(dot), .scanline(scanline),
    .renderEn(renderEn), .oddFrame(oddFrame), .ntscMode(ntscMode),
    .vramAddr(vramAddr), .bgPatSel(bgPatSel), .rdData(rdData),
    .busAddr(busAddr), .rdStrobe(rdStrobe), .skipDot(skipDot),
    .tileIdx(tileIdx), .palOffset(palOffset), .patLo(patLo), .patHi(patHi),
    .shiftLo(shiftLo), .shiftHi(shiftHi)
  );

  task automatic check(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h (line %0d dot %0d)", tag, got, exp, scanline, dot);
    end
  endtask

  task automatic checkRegs(string tag);
    check({tag, " tileIdx"}, int'(tileIdx), int'(eTile));
    check({tag, " palOffset"}, int'(palOffset), int'(ePal));
    check({tag, " patLo"}, int'(patLo), int'(eLo));
    check({tag, " patHi"}, int'(patHi), int'(eHi));
    check({tag, " shiftLo"}, int'(shiftLo), int'(eShL));
    check({tag, " shiftHi"}, int'(shiftHi), int'(eShH));
  endtask

  // One dot: outputs decoded in the same cycle, registers after the closing edge.
  task automatic runDot(int line, int d);
    int v, m, expA, sh;
    bit act, tileReg, sprReg, rd;
    string tag;
    logic [7:0] dat;
    @(negedge clk);
    scanline = 9'(line);
    dot = 9'(d);
    #2;
    v = int'(vramAddr);
    m = d % 8;
    act = renderEn && (line < 240 || line == 261);
    tileReg = (d >= 1 && d <= 256) || (d >= 321 && d <= 336);
    sprReg = (d >= 257 && d <= 320);
    rd = 1'b0;
    expA = 0;
    tag = act ? (tileReg ? "R2" : (sprReg ? "R6" : "R7")) : "R10";
    if (act) begin
      if (tileReg) begin
        if (m == 1) begin rd = 1; expA = 'h2000 | (v & 'h0FFF); end
        if (m == 2) begin rd = 1; expA = 'h23C0 | (v & 'h0C00) | ((v >> 4) & 'h38) | ((v >> 2) & 'h07); tag = "R3"; end
        if (m == 3) begin rd = 1; expA = (bgPatSel ? 'h1000 : 0) | (int'(eTile) << 4) | (v >> 12); tag = "R4"; end
        if (m == 5) begin rd = 1; expA = ((bgPatSel ? 'h1000 : 0) | (int'(eTile) << 4) | (v >> 12)) + 8; tag = "R4"; end
      end else if (sprReg) begin
        if (m == 1) begin rd = 1; expA = 'h2000 | (v & 'h0FFF); end
        if (m == 3) begin rd = 1; expA = 'h23C0 | (v & 'h0C00) | ((v >> 4) & 'h38) | ((v >> 2) & 'h07); end
      end else if (d == 337 || d == 339) begin
        rd = 1; expA = 'h2000 | (v & 'h0FFF);
      end
    end
    check({tag, " rdStrobe"}, int'(rdStrobe), int'(rd));
    check({tag, " busAddr"}, int'(busAddr), expA);
    check("R9 skipDot", int'(skipDot),
          int'(renderEn && ntscMode && oddFrame && line == 261 && d == 339));
    dat = memFn(14'(expA));
    if (act && tileReg) begin
      eShL = {eShL[14:0], 1'b0} | ((m == 1) ? {8'h00, eLo} : 16'h0);
      eShH = {eShH[14:0], 1'b0} | ((m == 1) ? {8'h00, eHi} : 16'h0);
      if (m == 1) eTile = dat;
      if (m == 2) begin
        sh = ((v >> 4) & 4) | (v & 2);
        ePal = 4'(((int'(dat) >> sh) & 3) << 2);
      end
      if (m == 3) eLo = dat;
      if (m == 5) eHi = dat;
    end
    @(posedge clk);
    #2;
    checkRegs(act ? (tileReg ? "R5 R8" : "R6 R7") : "R10");
  endtask

  task automatic runLine(int line);
    for (int d = 0; d <= 340; d++) runDot(line, d);
  endtask

  task automatic testReset();
    #2;
    check("R1 rdStrobe", int'(rdStrobe), 0);
    checkRegs("R1");
  endtask

  task automatic testVisible(logic [14:0] v, logic sel, int line);
    renderEn = 1'b1;
    vramAddr = v;
    bgPatSel = sel;
    runLine(line);
  endtask

  task automatic testSkip();
    renderEn = 1'b1; ntscMode = 1'b1; oddFrame = 1'b1;
    runLine(261);
    oddFrame = 1'b0;
    runDot(261, 339);
    oddFrame = 1'b1; ntscMode = 1'b0;
    runDot(261, 339);
    ntscMode = 1'b1;
    runDot(5, 339);
    ntscMode = 1'b0; oddFrame = 1'b0;
  endtask

  task automatic testQuiet();
    renderEn = 1'b0;
    vramAddr = 15'h1234;
    runLine(20);
    renderEn = 1'b1;
    runLine(245);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout exp=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    testVisible(15'h0000, 1'b0, 0);
    testVisible(15'h7FFF, 1'b1, 239);
    testVisible(15'h2A55, 1'b0, 100);
    testVisible(15'h5042, 1'b1, 17);
    testVisible(15'h13BD, 1'b0, 261);
    testSkip();
    testQuiet();
    testVisible(15'h6C81, 1'b1, 50);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule